// File: doc/BRIEF.md
# External Memory Bus Controller

This block lets a small processor core reach an external parallel memory through table-style byte reads and writes. The core issues a one-cycle request with a byte address, a read/write flag and a data byte. The controller turns it into one access on a 16-bit external data bus. It drives the word address, the data, the upper and lower byte enables, the high and low write strobes and a read strobe. It stretches each access by a programmable number of wait cycles and answers the core with a single-cycle acknowledge.

An eight-bit control register holds three fields. The bus-release bit sits at bit 7, the wait code at bits 5:4 and the wide-write mode at bits 1:0. The wait code is inverted: a larger code means fewer wait cycles. The wide-write mode picks one of three strobe schemes for writes onto the 16-bit bus, and one of these schemes merges two byte writes into a single word. The same register also decides who owns the shared pins. The bus either holds them permanently, or it hands them to general-purpose output and takes them back only while an access runs. The register is frozen while the device runs from internal program memory only.

Top module: `xmb_ctrl`

## Requirements
- R1: After reset the control register reads 0x00, the bus owns the pins (`bus_own`=1), `ack` is 0 and all strobes and enables are 0.
- R2: `cfg_rdata` returns the release bit at bit 7, the wait code at bits 5:4 and the write mode at bits 1:0; bits 6, 3 and 2 always read 0 (writing 0xFF reads back 0xB3).
- R3: A control write while `int_only` is 1 leaves the register unchanged.
- R4: An accepted bus access keeps its strobes active for 1+N cycles, where N = 3 minus the wait code (code 3 gives 0, 2 gives 1, 1 gives 2, 0 gives 3). `ack` rises on the clock edge that ends the access and stays high for exactly one cycle. A request driven before edge k therefore shows `ack` between edges k+1+N and k+2+N.
- R5: With the release bit 0 the bus always owns the pins. With it 1, `bus_own` is 0 and `pad_dout` equals `gpio_dout` while idle, and `bus_own` is 1 with `pad_dout` equal to `bus_dout` throughout an access.
- R6: Write mode 00: the byte appears on both halves of `bus_dout`; only `bus_wrh` fires for an odd address and only `bus_wrl` for an even one; both byte enables stay 0.
- R7: Write mode 01: the byte appears on both halves of `bus_dout`; `bus_wrh` fires together with `bus_ube` for an odd address or `bus_lbe` for an even one; `bus_wrl` stays 0.
- R8: Write mode 1x, odd address: `bus_dout` = {written byte, last latched low byte}, `bus_wrh`, `bus_ube` and `bus_lbe` are 1, and `bus_wrl` is 0.
- R9: Write mode 1x, even address: the byte is latched with no bus cycle (no strobe, no ownership change), and `ack` appears after the next clock edge.
- R10: A read asserts `bus_rd` with `bus_ube` (odd address) or `bus_lbe` (even address), keeps `bus_oe` 0, and returns on `rd_data` the upper or lower byte of `bus_din` sampled in the last access cycle.
- R11: During an access `bus_addr` equals the byte address shifted right by one and `bus_oe` is 1 for writes.
- R12: A request that arrives while an access is running is ignored. A request accepted in the same cycle as a control write uses the previous register settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| int_only | input | 1 | Device runs from internal program memory only; locks the control register |
| cfg_we | input | 1 | Control register write enable |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register read data |
| req | input | 1 | One-cycle access request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address; bit 0 selects the upper (1) or lower (0) byte |
| req_wdata | input | 8 | Write byte |
| ack | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Byte returned by the last read |
| bus_addr | output | ADDR_W-1 | External word address |
| bus_dout | output | 16 | External write data |
| bus_din | input | 16 | External read data |
| bus_oe | output | 1 | Data bus output enable |
| bus_rd | output | 1 | Read strobe |
| bus_wrh | output | 1 | High write strobe |
| bus_wrl | output | 1 | Low write strobe |
| bus_ube | output | 1 | Upper byte enable |
| bus_lbe | output | 1 | Lower byte enable |
| bus_own | output | 1 | Shared pins belong to the bus |
| gpio_dout | input | PAD_W | General-purpose output values for the shared pins |
| pad_dout | output | PAD_W | Value driven onto the shared pins |

## Verification
Two functions can fall in the same clock cycle: a control register update and the acceptance of a new access. A second collision is a fresh request landing while an access is still counting its wait cycles. The bench drives a control write and a request on the same edge. It then judges the acknowledge latency against the old wait code and reads back the new value afterwards. It also pulses a second request in the middle of a long access and checks that exactly one acknowledge appears and that the bus data never changes to the intruding byte.

// File: rtl/xmb_pkg.sv
package xmb_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;
    localparam int WAIT_W = 2;

    // Control register bit positions (software decodes these).
    localparam int CFG_REL_BIT  = 7;
    localparam int CFG_WAIT_LSB = 4;
    localparam int CFG_MODE_LSB = 0;

    typedef struct packed {
        logic              release_pins;
        logic [WAIT_W-1:0] wait_code;
        logic [1:0]        wmode;
    } cfg_t;

    typedef struct packed {
        logic oe;
        logic rd;
        logic wrh;
        logic wrl;
        logic ube;
        logic lbe;
    } strb_t;

endpackage

// File: rtl/xmb_cfg_reg.sv
module xmb_cfg_reg
    import xmb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              int_only,
    input  logic              cfg_we,
    input  logic [BYTE_W-1:0] cfg_wdata,
    output logic [BYTE_W-1:0] cfg_rdata,
    output cfg_t              cfg
);

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we && !int_only) begin
            cfg_d.release_pins = cfg_wdata[CFG_REL_BIT];
            cfg_d.wait_code    = cfg_wdata[CFG_WAIT_LSB +: WAIT_W];
            cfg_d.wmode        = cfg_wdata[CFG_MODE_LSB +: 2];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        cfg_rdata                         = '0;
        cfg_rdata[CFG_REL_BIT]            = cfg_q.release_pins;
        cfg_rdata[CFG_WAIT_LSB +: WAIT_W] = cfg_q.wait_code;
        cfg_rdata[CFG_MODE_LSB +: 2]      = cfg_q.wmode;
    end

    assign cfg = cfg_q;

    AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (int_only && cfg_we) |=> $stable(cfg_q)); // R3

endmodule

// File: rtl/xmb_seq.sv
module xmb_seq
    import xmb_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cfg_t              cfg,
    input  logic              req,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BYTE_W-1:0] req_wdata,
    input  logic [WORD_W-1:0] bus_din,
    output logic              ack,
    output logic [BYTE_W-1:0] rd_data,
    output logic [ADDR_W-2:0] bus_addr,
    output logic [WORD_W-1:0] bus_dout,
    output strb_t             strb,
    output logic              busy
);

    typedef struct packed {
        logic              busy;
        logic [WAIT_W-1:0] cnt;
        logic              rd_acc;
        logic              lsb;
        logic [ADDR_W-2:0] addr;
        logic [WORD_W-1:0] dout;
        strb_t             strb;
        logic [BYTE_W-1:0] lo;
        logic              ack;
        logic [BYTE_W-1:0] rdata;
    } st_t;

    st_t st_d, st_q;
    logic a0;

    assign a0 = req_addr[0];

    always_comb begin
        st_d     = st_q;
        st_d.ack = 1'b0;
        if (!st_q.busy) begin
            if (req) begin
                if (req_we && cfg.wmode[1] && !a0) begin
                    // word mode, low half: latch only
                    st_d.lo  = req_wdata;
                    st_d.ack = 1'b1;
                end else begin
                    st_d.busy   = 1'b1;
                    st_d.cnt    = ~cfg.wait_code;
                    st_d.addr   = req_addr[ADDR_W-1:1];
                    st_d.lsb    = a0;
                    st_d.rd_acc = !req_we;
                    st_d.dout   = '0;
                    st_d.strb   = '0;
                    if (!req_we) begin
                        st_d.strb.rd  = 1'b1;
                        st_d.strb.ube = a0;
                        st_d.strb.lbe = !a0;
                    end else if (cfg.wmode[1]) begin
                        st_d.dout     = {req_wdata, st_q.lo};
                        st_d.strb.oe  = 1'b1;
                        st_d.strb.wrh = 1'b1;
                        st_d.strb.ube = 1'b1;
                        st_d.strb.lbe = 1'b1;
                    end else if (cfg.wmode[0]) begin
                        st_d.dout     = {req_wdata, req_wdata};
                        st_d.strb.oe  = 1'b1;
                        st_d.strb.wrh = 1'b1;
                        st_d.strb.ube = a0;
                        st_d.strb.lbe = !a0;
                    end else begin
                        st_d.dout     = {req_wdata, req_wdata};
                        st_d.strb.oe  = 1'b1;
                        st_d.strb.wrh = a0;
                        st_d.strb.wrl = !a0;
                    end
                end
            end
        end else if (st_q.cnt == '0) begin
            st_d.busy = 1'b0;
            st_d.ack  = 1'b1;
            st_d.strb = '0;
            st_d.dout = '0;
            if (st_q.rd_acc)
                st_d.rdata = st_q.lsb ? bus_din[WORD_W-1:BYTE_W] : bus_din[BYTE_W-1:0];
        end else begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ack      = st_q.ack;
    assign rd_data  = st_q.rdata;
    assign bus_addr = st_q.addr;
    assign bus_dout = st_q.dout;
    assign strb     = st_q.strb;
    assign busy     = st_q.busy;

    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack); // R4
    AST_ACK_ENDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ack); // R4
    AST_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(strb.wrh && strb.wrl)); // R6
    AST_NO_RD_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        strb.rd |-> !strb.oe); // R10

endmodule

// File: rtl/xmb_pin_mux.sv
module xmb_pin_mux #(
    parameter int PAD_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             release_pins,
    input  logic             busy,
    input  logic [PAD_W-1:0] bus_side,
    input  logic [PAD_W-1:0] gpio_side,
    output logic             own,
    output logic [PAD_W-1:0] pad
);

    assign own = !release_pins || busy;

    for (genvar i = 0; i < PAD_W; i++) begin : g_pad
        assign pad[i] = own ? bus_side[i] : gpio_side[i];
    end

    AST_OWN_DURING_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (own && pad == bus_side)); // R5

endmodule

// File: rtl/xmb_ctrl.sv
module xmb_ctrl
    import xmb_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int PAD_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              int_only,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic              req,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        req_wdata,
    output logic              ack,
    output logic [7:0]        rd_data,
    output logic [ADDR_W-2:0] bus_addr,
    output logic [15:0]       bus_dout,
    input  logic [15:0]       bus_din,
    output logic              bus_oe,
    output logic              bus_rd,
    output logic              bus_wrh,
    output logic              bus_wrl,
    output logic              bus_ube,
    output logic              bus_lbe,
    output logic              bus_own,
    input  logic [PAD_W-1:0]  gpio_dout,
    output logic [PAD_W-1:0]  pad_dout
);

    localparam int COPY_W = (PAD_W < WORD_W) ? PAD_W : WORD_W;

    cfg_t             cfg;
    strb_t            strb;
    logic             busy;
    logic [PAD_W-1:0] bus_side;

    xmb_cfg_reg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .int_only  (int_only),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .cfg       (cfg)
    );

    xmb_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg       (cfg),
        .req       (req),
        .req_we    (req_we),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .bus_din   (bus_din),
        .ack       (ack),
        .rd_data   (rd_data),
        .bus_addr  (bus_addr),
        .bus_dout  (bus_dout),
        .strb      (strb),
        .busy      (busy)
    );

    always_comb begin
        bus_side             = '0;
        bus_side[COPY_W-1:0] = bus_dout[COPY_W-1:0];
    end

    xmb_pin_mux #(.PAD_W(PAD_W)) u_pins (
        .clk          (clk),
        .rst_n        (rst_n),
        .release_pins (cfg.release_pins),
        .busy         (busy),
        .bus_side     (bus_side),
        .gpio_side    (gpio_dout),
        .own          (bus_own),
        .pad          (pad_dout)
    );

    assign bus_oe  = strb.oe;
    assign bus_rd  = strb.rd;
    assign bus_wrh = strb.wrh;
    assign bus_wrl = strb.wrl;
    assign bus_ube = strb.ube;
    assign bus_lbe = strb.lbe;

endmodule

// File: tb/xmb_ctrl_tb_top.sv
`timescale 1ns/1ps
module xmb_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        int_only = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic        req = 1'b0;
    logic        req_we = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        ack;
    logic [7:0]  rd_data;
    logic [14:0] bus_addr;
    logic [15:0] bus_dout;
    logic [15:0] bus_din = 16'hC35A;
    logic        bus_oe, bus_rd, bus_wrh, bus_wrl, bus_ube, bus_lbe, bus_own;
    logic [15:0] gpio_dout = 16'h6E91;
    logic [15:0] pad_dout;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    xmb_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .int_only(int_only),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .req(req), .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
        .ack(ack), .rd_data(rd_data), .bus_addr(bus_addr), .bus_dout(bus_dout),
        .bus_din(bus_din), .bus_oe(bus_oe), .bus_rd(bus_rd), .bus_wrh(bus_wrh),
        .bus_wrl(bus_wrl), .bus_ube(bus_ube), .bus_lbe(bus_lbe), .bus_own(bus_own),
        .gpio_dout(gpio_dout), .pad_dout(pad_dout)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    task automatic cfg_write(input logic [7:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Drives a request at a negedge, returns strobes seen in the first
    // access cycle, the data, the address and the ack latency in negedges.
    task automatic access(input logic we, input logic [15:0] a, input logic [7:0] d,
                          output logic [5:0] st, output logic [15:0] dq,
                          output logic [14:0] aq, output int lat);
        @(negedge clk);
        req = 1'b1; req_we = we; req_addr = a; req_wdata = d;
        @(negedge clk);
        req = 1'b0;
        st  = {bus_oe, bus_rd, bus_wrh, bus_wrl, bus_ube, bus_lbe};
        dq  = bus_dout;
        aq  = bus_addr;
        lat = 1;
        while (!ack && lat < 20) begin
            @(negedge clk);
            lat++;
        end
    endtask

    typedef struct packed {
        logic [7:0]  cfg;
        logic        we;
        logic [15:0] addr;
        logic [7:0]  data;
        logic [15:0] dout;
        logic [3:0]  strb;   // {wrh, wrl, ube, lbe}
        logic [3:0]  lat;
        logic [7:0]  rdata;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{8'h00, 1'b1, 16'h0010, 8'h3C, 16'h3C3C, 4'b0100, 4'd5, 8'h00}, // R6 wait0 even
        '{8'h30, 1'b1, 16'h0011, 8'h81, 16'h8181, 4'b1000, 4'd2, 8'h00}, // R6 wait3 odd
        '{8'h21, 1'b1, 16'h0020, 8'h7E, 16'h7E7E, 4'b1001, 4'd3, 8'h00}, // R7 even
        '{8'h11, 1'b1, 16'h0021, 8'h42, 16'h4242, 4'b1010, 4'd4, 8'h00}, // R7 odd
        '{8'h32, 1'b1, 16'h0040, 8'hAA, 16'h0000, 4'b0000, 4'd1, 8'h00}, // R9 latch
        '{8'h32, 1'b1, 16'h0041, 8'h55, 16'h55AA, 4'b1011, 4'd2, 8'h00}, // R8
        '{8'h03, 1'b1, 16'h0050, 8'h11, 16'h0000, 4'b0000, 4'd1, 8'h00}, // R9 mode 11
        '{8'h03, 1'b1, 16'h0051, 8'h22, 16'h2211, 4'b1011, 4'd5, 8'h00}, // R8 mode 11
        '{8'h20, 1'b0, 16'h0061, 8'h00, 16'h0000, 4'b0010, 4'd3, 8'hC3}, // R10 odd
        '{8'h30, 1'b0, 16'h0062, 8'h00, 16'h0000, 4'b0001, 4'd2, 8'h5A}  // R10 even
    };

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [5:0]  st;
        logic [15:0] dq;
        logic [14:0] aq;
        int          lat;
        int          nack;

        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 cfg reset", cfg_rdata, 8'h00);
        chk("R1 own", bus_own, 1'b1);
        chk("R1 ack", ack, 1'b0);
        chk("R1 strobes", {bus_oe, bus_rd, bus_wrh, bus_wrl, bus_ube, bus_lbe}, 6'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 strobes after release", {bus_oe, bus_rd, bus_wrh, bus_wrl, bus_ube, bus_lbe}, 6'b0);

        // R2 readback with reserved zeros
        cfg_write(8'hFF);
        chk("R2 readback", cfg_rdata, 8'hB3);
        // R3 locked while internal-only
        int_only = 1'b1;
        cfg_write(8'h00);
        chk("R3 locked", cfg_rdata, 8'hB3);
        int_only = 1'b0;

        // Vector table: R4 R6 R7 R8 R9 R10 R11
        for (int i = 0; i < NV; i++) begin
            cfg_write(VEC[i].cfg);
            access(VEC[i].we, VEC[i].addr, VEC[i].data, st, dq, aq, lat);
            chk($sformatf("R4 latency v%0d", i), lat, VEC[i].lat);
            chk($sformatf("R6/R7/R8 strobes v%0d", i), st[3:0], VEC[i].strb);
            chk($sformatf("R10 rd v%0d", i), st[4], (VEC[i].strb != 0) && !VEC[i].we);
            chk($sformatf("R11 oe v%0d", i), st[5], (VEC[i].strb != 0) && VEC[i].we);
            chk($sformatf("R8 dout v%0d", i), dq, VEC[i].dout);
            if (VEC[i].strb != 0)
                chk($sformatf("R11 addr v%0d", i), aq, VEC[i].addr[15:1]);
            @(negedge clk);
            chk($sformatf("R4 ack one cycle v%0d", i), ack, 1'b0);
            if (!VEC[i].we)
                chk($sformatf("R10 rdata v%0d", i), rd_data, VEC[i].rdata);
        end

        // R5 release bit: pins to gpio while idle, taken during access
        cfg_write(8'hB0);
        chk("R5 idle own", bus_own, 1'b0);
        chk("R5 idle pad", pad_dout, gpio_dout);
        @(negedge clk);
        req = 1'b1; req_we = 1'b1; req_addr = 16'h0071; req_wdata = 8'hE7;
        @(negedge clk);
        req = 1'b0;
        chk("R5 access own", bus_own, 1'b1);
        chk("R5 access pad", pad_dout, 16'hE7E7);
        @(negedge clk);
        chk("R5 ack", ack, 1'b1);
        chk("R5 released", bus_own, 1'b0);
        cfg_write(8'h30);
        chk("R5 permanent own", bus_own, 1'b1);
        chk("R5 permanent pad", pad_dout, 16'h0000);

        // R12 request during a running access is ignored
        cfg_write(8'h00);
        @(negedge clk);
        req = 1'b1; req_we = 1'b1; req_addr = 16'h0010; req_wdata = 8'h3C;
        @(negedge clk);
        req = 1'b0;
        @(negedge clk);
        req = 1'b1; req_addr = 16'h0011; req_wdata = 8'h99;
        @(negedge clk);
        req = 1'b0;
        chk("R12 dout held", bus_dout, 16'h3C3C);
        chk("R12 strobe held", {bus_wrh, bus_wrl}, 2'b01);
        nack = 0;
        for (int k = 0; k < 12; k++) begin
            if (ack) nack++;
            @(negedge clk);
        end
        chk("R12 single ack", nack, 1);

        // R12 control write in same cycle as request uses old wait code
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = 8'h30;
        req = 1'b1; req_we = 1'b0; req_addr = 16'h0080;
        @(negedge clk);
        cfg_we = 1'b0; req = 1'b0;
        lat = 1;
        while (!ack && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        chk("R12 old wait used", lat, 5);
        chk("R12 new cfg stored", cfg_rdata, 8'h30);

        finish_run();
    end

endmodule